// File: doc/BRIEF.md
# Instruction Cache Control and Flush Arbiter

This block owns the configuration word of a small instruction cache and decides how run-time maintenance commands interact with writes to that word. The word carries an on bit, a lock bit, a debug-mode bit and a lower and an upper line boundary for replacement. From these the block derives the effective cache-enable. It applies full-flush and boundary-range-flush commands to a 16-entry valid-bit array, which stands in for the tag and data storage. While a command's penalty runs, the block holds a stall output high.

Software reads the configuration word back through a delayed copy. That copy only catches up after two execution-set strobes have followed a write. Debug reads of the valid array are served only in debug mode, and only after one execution set has passed since debug mode was entered. A refused read raises a sticky exception flag, which software clears by writing a one. A line-fill input stands in for allocation, so that lines can be marked valid while the cache is enabled.

Commands use plain pins, not a handshake. A command offered while stall is high is dropped rather than held, so the caller must wait for stall to fall before it offers the next one.

Top module: `icache_ctl_arb`

## Requirements
- R1: After a configuration write, cfg_rd_data keeps its old value until the second exec_set strobe in a later cycle than the write. The new value is visible from the cycle after that strobe. A fresh write restarts the count.
- R2: The word layout is bit 0 on, bit 1 lock, bit 2 debug, bits 6:3 lower boundary, bits 10:7 upper boundary. cache_en is high only when on is 1, lock is 0, debug is 0, lower is less than or equal to upper, and stall is low.
- R3: An accepted full flush clears all 16 valid bits and holds stall high for 2 cycles.
- R4: An accepted range flush clears lines lower to upper inclusive and holds stall high for 4 cycles. When lower is greater than upper, no line is cleared, but the stall still runs.
- R5: A range flush in the same cycle as a configuration write uses the boundaries being written.
- R6: A flush in the same cycle as a write that disables the cache (on cleared, or lock or debug set) is still carried out.
- R7: A full flush and a range flush offered together clear all lines and stall for 4 cycles.
- R8: While stall is high, cache_en is low, new flush commands are ignored without extending the stall, and fills set no valid bit.
- R9: A debug read returns the valid array on dbg_rd_data, with dbg_rd_valid high one cycle later, only when the debug bit is set and armed. Any other debug read raises exc_flag, and exc_flag stays high until it is cleared.
- R10: Debug mode becomes armed only on an exec_set strobe in a later cycle than the write that set the debug bit. Before that strobe, debug reads are refused.
- R11: Writing sts_wr_en with sts_wr_data = 1 clears exc_flag. A refused read in the same cycle wins, and the flag stays set.
- R12: Synchronous reset clears the configuration word, the read-back copy, the valid array, stall and exc_flag.
- R13: A fill sets the valid bit of line fill_idx only while cache_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_set | input | 1 | One pulse per execution set |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 11 | Configuration word to write |
| cfg_rd_data | output | 11 | Delayed read-back of the configuration word |
| cmd_full_flush | input | 1 | Full flush command |
| cmd_range_flush | input | 1 | Boundary range flush command |
| fill_en | input | 1 | Line fill strobe |
| fill_idx | input | 4 | Line to mark valid |
| dbg_rd_req | input | 1 | Debug read of the valid array |
| dbg_rd_valid | output | 1 | Debug read data valid |
| dbg_rd_data | output | 16 | Valid array snapshot |
| sts_wr_en | input | 1 | Status write strobe |
| sts_wr_data | input | 1 | Writing 1 clears exc_flag |
| cache_en | output | 1 | Effective cache enable |
| stall | output | 1 | Core stall during command penalty |
| valid_bits | output | 16 | Valid array contents |
| exc_flag | output | 1 | Sticky refused-debug-access flag |

## Verification
Every state change lands on the clock edge after the inputs that cause it. cache_en follows combinationally from the registered word and stall. The bench drives on the falling edge, so each valid-array, flag, debug-read and read-back result is sampled at the next falling edge, one cycle after the stimulus. Stall length is measured by counting the consecutive falling edges at which stall is high, starting at the first falling edge after the accepting edge. This gives exactly 2 or 4 for a correct design. The read-back rule is checked after one strobe, where the old value must still show, and again after the second strobe, where the new value must show.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam int ON_BIT   = 0;
  localparam int LOCK_BIT = 1;
  localparam int DBG_BIT  = 2;
  localparam int LO_POS   = 3;

  // bit 0 = full flush, bit 1 = range flush
  typedef enum logic [1:0] {
    FK_NONE  = 2'b00,
    FK_FULL  = 2'b01,
    FK_RANGE = 2'b10,
    FK_BOTH  = 2'b11
  } flush_kind_e;
endpackage

// File: rtl/icc_ctrl_reg.sv
module icc_ctrl_reg
  import icc_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exec_set,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] ctrl_q,
  output logic [CW-1:0] vis_q,
  output logic          dbg_armed
);
  logic pend_q;
  logic age_q;
  logic arm_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      vis_q      <= '0;
      pend_q     <= 1'b0;
      age_q      <= 1'b0;
      dbg_armed  <= 1'b0;
      arm_pend_q <= 1'b0;
    end else begin
      if (wr_en) begin
        ctrl_q <= wr_data;
        pend_q <= 1'b1;
        age_q  <= 1'b0;
      end else if (pend_q && exec_set) begin
        if (age_q) begin
          vis_q  <= ctrl_q;
          pend_q <= 1'b0;
        end else begin
          age_q <= 1'b1;
        end
      end

      if (wr_en) begin
        if (!wr_data[DBG_BIT]) begin
          dbg_armed  <= 1'b0;
          arm_pend_q <= 1'b0;
        end else if (!ctrl_q[DBG_BIT]) begin
          dbg_armed  <= 1'b0;
          arm_pend_q <= 1'b1;
        end
      end else if (arm_pend_q && exec_set) begin
        dbg_armed  <= 1'b1;
        arm_pend_q <= 1'b0;
      end
    end
  end

  // R1: read-back copy only moves on a strobe while an update is pending
  a_r1_vis_hold: assert property (@(posedge clk) disable iff (rst)
    !(pend_q && exec_set) |=> $stable(vis_q));

  // R10: arming always follows an execution-set strobe
  a_r10_arm_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(dbg_armed) |-> $past(exec_set));
endmodule

// File: rtl/icc_range_mask.sv
module icc_range_mask #(
  parameter int LINES = 16,
  parameter int LW    = $clog2(LINES)
) (
  input  logic [LW-1:0]    lo,
  input  logic [LW-1:0]    hi,
  output logic [LINES-1:0] mask
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign mask[i] = (LW'(i) >= lo) && (LW'(i) <= hi);
  end
endmodule

// File: rtl/icc_flush_arb.sv
module icc_flush_arb
  import icc_pkg::*;
#(
  parameter int LINES     = 16,
  parameter int LW        = $clog2(LINES),
  parameter int FULL_PEN  = 2,
  parameter int RANGE_PEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  flush_kind_e      kind,
  input  logic [LINES-1:0] range_mask,
  input  logic             fill_en,
  input  logic [LW-1:0]    fill_idx,
  input  logic             fill_ok,
  output logic [LINES-1:0] valid_q,
  output logic             stall,
  output logic             acc_full
);
  localparam int BOTH_PEN = (RANGE_PEN > FULL_PEN) ? RANGE_PEN : FULL_PEN;
  localparam int CNT_W    = $clog2(BOTH_PEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pen;
  logic [LINES-1:0] clr;
  logic             acc;

  assign stall    = (cnt_q != '0);
  assign acc      = (kind != FK_NONE) && !stall;
  assign acc_full = acc && ((kind == FK_FULL) || (kind == FK_BOTH));

  always_comb begin
    pen = '0;
    clr = '0;
    case (kind)
      FK_FULL:  begin pen = CNT_W'(FULL_PEN);  clr = '1;         end
      FK_RANGE: begin pen = CNT_W'(RANGE_PEN); clr = range_mask; end
      FK_BOTH:  begin pen = CNT_W'(BOTH_PEN);  clr = '1;         end
      default:  begin pen = '0;                clr = '0;         end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      cnt_q   <= '0;
    end else if (acc) begin
      cnt_q   <= pen;
      valid_q <= valid_q & ~clr;
    end else begin
      if (stall) cnt_q <= cnt_q - 1'b1;
      if (fill_en && fill_ok && !stall) valid_q[fill_idx] <= 1'b1;
    end
  end

  // R3: a full flush leaves no line valid
  a_r3_full_clears: assert property (@(posedge clk) disable iff (rst)
    acc_full |=> (valid_q == '0));

  // R8: no line becomes valid while stalled
  a_r8_no_fill_in_stall: assert property (@(posedge clk) disable iff (rst)
    stall |=> ((valid_q & ~$past(valid_q)) == '0));

  // R7: stall never exceeds the longest penalty
  a_r7_stall_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(BOTH_PEN));
endmodule

// File: rtl/icache_ctl_arb.sv
module icache_ctl_arb
  import icc_pkg::*;
#(
  parameter int  LINES     = 16,
  parameter int  FULL_PEN  = 2,
  parameter int  RANGE_PEN = 4,
  localparam int LW        = $clog2(LINES),
  localparam int CW        = 3 + 2 * LW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             exec_set,
  input  logic             cfg_wr_en,
  input  logic [CW-1:0]    cfg_wr_data,
  output logic [CW-1:0]    cfg_rd_data,
  input  logic             cmd_full_flush,
  input  logic             cmd_range_flush,
  input  logic             fill_en,
  input  logic [LW-1:0]    fill_idx,
  input  logic             dbg_rd_req,
  output logic             dbg_rd_valid,
  output logic [LINES-1:0] dbg_rd_data,
  input  logic             sts_wr_en,
  input  logic             sts_wr_data,
  output logic             cache_en,
  output logic             stall,
  output logic [LINES-1:0] valid_bits,
  output logic             exc_flag
);
  localparam int HI_POS = LO_POS + LW;

  logic [CW-1:0]    ctrl_q;
  logic             dbg_armed;
  logic [LW-1:0]    cur_lo, cur_hi, fl_lo, fl_hi;
  logic [LINES-1:0] range_mask;
  logic             acc_full;
  logic             dbg_ok;
  flush_kind_e      kind;

  icc_ctrl_reg #(.CW(CW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .exec_set (exec_set),
    .wr_en    (cfg_wr_en),
    .wr_data  (cfg_wr_data),
    .ctrl_q   (ctrl_q),
    .vis_q    (cfg_rd_data),
    .dbg_armed(dbg_armed)
  );

  assign cur_lo = ctrl_q[LO_POS +: LW];
  assign cur_hi = ctrl_q[HI_POS +: LW];

  // a range flush alongside a write uses the boundaries being written
  assign fl_lo = cfg_wr_en ? cfg_wr_data[LO_POS +: LW] : cur_lo;
  assign fl_hi = cfg_wr_en ? cfg_wr_data[HI_POS +: LW] : cur_hi;

  icc_range_mask #(.LINES(LINES), .LW(LW)) u_mask (
    .lo  (fl_lo),
    .hi  (fl_hi),
    .mask(range_mask)
  );

  assign kind = flush_kind_e'({cmd_range_flush, cmd_full_flush});

  assign cache_en = ctrl_q[ON_BIT] && !ctrl_q[LOCK_BIT] && !ctrl_q[DBG_BIT]
                    && (cur_lo <= cur_hi) && !stall;

  icc_flush_arb #(
    .LINES    (LINES),
    .LW       (LW),
    .FULL_PEN (FULL_PEN),
    .RANGE_PEN(RANGE_PEN)
  ) u_arb (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .range_mask(range_mask),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_ok   (cache_en),
    .valid_q   (valid_bits),
    .stall     (stall),
    .acc_full  (acc_full)
  );

  assign dbg_ok = dbg_rd_req && ctrl_q[DBG_BIT] && dbg_armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_rd_valid <= 1'b0;
      dbg_rd_data  <= '0;
      exc_flag     <= 1'b0;
    end else begin
      dbg_rd_valid <= dbg_ok;
      if (dbg_ok) dbg_rd_data <= valid_bits;
      if (dbg_rd_req && !dbg_ok)           exc_flag <= 1'b1;
      else if (sts_wr_en && sts_wr_data)   exc_flag <= 1'b0;
    end
  end

  // R2: enable requires on set and debug clear in the stored word
  a_r2_en_needs_on: assert property (@(posedge clk) disable iff (rst)
    cache_en |-> (ctrl_q[ON_BIT] && !ctrl_q[DBG_BIT]));

  // R8: cache behaves as locked while a command runs
  a_r8_locked_in_stall: assert property (@(posedge clk) disable iff (rst)
    stall |-> !cache_en);

  // R9: debug data only delivered when the request saw debug mode
  a_r9_rd_in_debug: assert property (@(posedge clk) disable iff (rst)
    dbg_rd_valid |-> $past(ctrl_q[DBG_BIT]));

  // R11: flag holds unless a clear is written
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (exc_flag && !(sts_wr_en && sts_wr_data)) |=> exc_flag);
endmodule

// File: tb/icache_ctl_arb_tb.sv
`timescale 1ns/1ps
module icache_ctl_arb_tb_top;
  localparam int LINES = 16;
  localparam int LW    = 4;
  localparam int CW    = 11;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst;
  logic             exec_set;
  logic             cfg_wr_en;
  logic [CW-1:0]    cfg_wr_data;
  logic [CW-1:0]    cfg_rd_data;
  logic             cmd_full_flush, cmd_range_flush;
  logic             fill_en;
  logic [LW-1:0]    fill_idx;
  logic             dbg_rd_req, dbg_rd_valid;
  logic [LINES-1:0] dbg_rd_data;
  logic             sts_wr_en, sts_wr_data;
  logic             cache_en, stall, exc_flag;
  logic [LINES-1:0] valid_bits;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  icache_ctl_arb dut_i (
    .clk(clk), .rst(rst), .exec_set(exec_set),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .cmd_full_flush(cmd_full_flush), .cmd_range_flush(cmd_range_flush),
    .fill_en(fill_en), .fill_idx(fill_idx),
    .dbg_rd_req(dbg_rd_req), .dbg_rd_valid(dbg_rd_valid), .dbg_rd_data(dbg_rd_data),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
    .cache_en(cache_en), .stall(stall), .valid_bits(valid_bits), .exc_flag(exc_flag)
  );

  function automatic logic [CW-1:0] mk(input bit on, input bit lock, input bit dbg,
                                       input logic [3:0] lo, input logic [3:0] hi);
    return {hi, lo, dbg, lock, on};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [CW-1:0] v);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    tick();
    cfg_wr_en = 1'b0;
  endtask

  task automatic pulse_exec();
    exec_set = 1'b1;
    tick();
    exec_set = 1'b0;
  endtask

  task automatic fill_all();
    for (int i = 0; i < LINES; i++) begin
      fill_en = 1'b1; fill_idx = LW'(i);
      tick();
    end
    fill_en = 1'b0;
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (stall && n < 20) begin
      n++;
      tick();
    end
  endtask

  task automatic t_reset();
    chk(cfg_rd_data == '0, "R12 readback", 32'(cfg_rd_data), 0);
    chk(valid_bits == '0, "R12 valid", 32'(valid_bits), 0);
    chk(!stall && !cache_en && !exc_flag, "R12 flags",
        {29'd0, stall, cache_en, exc_flag}, 0);
  endtask

  task automatic t_readback();
    logic [CW-1:0] a;
    a = mk(1, 0, 0, 2, 13);
    wr_cfg(a);
    chk(cfg_rd_data == '0, "R1 no strobe", 32'(cfg_rd_data), 0);
    pulse_exec();
    chk(cfg_rd_data == '0, "R1 one strobe", 32'(cfg_rd_data), 0);
    pulse_exec();
    chk(cfg_rd_data == a, "R1 two strobes", 32'(cfg_rd_data), 32'(a));
  endtask

  task automatic t_enable();
    wr_cfg(mk(1, 0, 0, 0, 15)); chk(cache_en == 1, "R2 on", 32'(cache_en), 1);
    wr_cfg(mk(1, 1, 0, 0, 15)); chk(cache_en == 0, "R2 lock", 32'(cache_en), 0);
    wr_cfg(mk(1, 0, 1, 0, 15)); chk(cache_en == 0, "R2 debug", 32'(cache_en), 0);
    wr_cfg(mk(1, 0, 0, 9, 3));  chk(cache_en == 0, "R2 lo>hi", 32'(cache_en), 0);
    wr_cfg(mk(1, 0, 0, 7, 7));  chk(cache_en == 1, "R2 lo=hi", 32'(cache_en), 1);
    wr_cfg(mk(0, 0, 0, 0, 15)); chk(cache_en == 0, "R2 off", 32'(cache_en), 0);
  endtask

  task automatic t_full();
    int n;
    wr_cfg(mk(1, 0, 0, 0, 15));
    fill_all();
    chk(valid_bits == 16'hFFFF, "R13 fill", 32'(valid_bits), 32'hFFFF);
    cmd_full_flush = 1'b1; tick(); cmd_full_flush = 1'b0;
    chk(valid_bits == 16'h0, "R3 clear", 32'(valid_bits), 0);
    count_stall(n);
    chk(n == 2, "R3 stall", 32'(n), 2);
    wr_cfg(mk(0, 0, 0, 0, 15));
    fill_en = 1'b1; fill_idx = 4'd3; tick(); fill_en = 1'b0;
    chk(valid_bits == 16'h0, "R13 fill disabled", 32'(valid_bits), 0);
  endtask

  task automatic t_range();
    int n;
    wr_cfg(mk(1, 0, 0, 4, 9));
    fill_all();
    cmd_range_flush = 1'b1; tick(); cmd_range_flush = 1'b0;
    chk(valid_bits == 16'hFC0F, "R4 range", 32'(valid_bits), 32'hFC0F);
    count_stall(n);
    chk(n == 4, "R4 stall", 32'(n), 4);
  endtask

  task automatic t_stall_ignore();
    int n;
    wr_cfg(mk(1, 0, 0, 0, 15));
    fill_all();
    wr_cfg(mk(1, 0, 0, 0, 1));
    cmd_range_flush = 1'b1; tick(); cmd_range_flush = 1'b0;
    chk(cache_en == 0, "R8 locked", 32'(cache_en), 0);
    cmd_full_flush = 1'b1; fill_en = 1'b1; fill_idx = 4'd0;
    tick();
    cmd_full_flush = 1'b0; fill_en = 1'b0;
    count_stall(n);
    chk(n + 1 == 4, "R8 stall length", 32'(n + 1), 4);
    chk(valid_bits == 16'hFFFC, "R8 ignored", 32'(valid_bits), 32'hFFFC);
    wr_cfg(mk(1, 0, 0, 9, 3));
    cmd_range_flush = 1'b1; tick(); cmd_range_flush = 1'b0;
    chk(valid_bits == 16'hFFFC, "R4 empty range", 32'(valid_bits), 32'hFFFC);
    count_stall(n);
    chk(n == 4, "R4 empty stall", 32'(n), 4);
  endtask

  task automatic t_same_cycle();
    int n;
    wr_cfg(mk(1, 0, 0, 0, 15));
    fill_all();
    cfg_wr_en = 1'b1; cfg_wr_data = mk(1, 0, 0, 2, 3); cmd_range_flush = 1'b1;
    tick();
    cfg_wr_en = 1'b0; cmd_range_flush = 1'b0;
    chk(valid_bits == 16'hFFF3, "R5 new bounds", 32'(valid_bits), 32'hFFF3);
    count_stall(n);
  endtask

  task automatic t_disable();
    int n;
    wr_cfg(mk(1, 0, 0, 0, 15));
    fill_all();
    cfg_wr_en = 1'b1; cfg_wr_data = mk(0, 0, 0, 0, 15); cmd_full_flush = 1'b1;
    tick();
    cfg_wr_en = 1'b0; cmd_full_flush = 1'b0;
    chk(valid_bits == 16'h0, "R6 off+full", 32'(valid_bits), 0);
    count_stall(n);
    wr_cfg(mk(1, 0, 0, 0, 15));
    fill_all();
    cfg_wr_en = 1'b1; cfg_wr_data = mk(1, 1, 0, 0, 15); cmd_range_flush = 1'b1;
    tick();
    cfg_wr_en = 1'b0; cmd_range_flush = 1'b0;
    chk(valid_bits == 16'h0, "R6 lock+range", 32'(valid_bits), 0);
    count_stall(n);
  endtask

  task automatic t_both();
    int n;
    wr_cfg(mk(1, 0, 0, 4, 5));
    fill_all();
    cmd_full_flush = 1'b1; cmd_range_flush = 1'b1;
    tick();
    cmd_full_flush = 1'b0; cmd_range_flush = 1'b0;
    chk(valid_bits == 16'h0, "R7 full wins", 32'(valid_bits), 0);
    count_stall(n);
    chk(n == 4, "R7 long stall", 32'(n), 4);
  endtask

  task automatic t_debug();
    wr_cfg(mk(1, 0, 0, 0, 15));
    fill_all();
    dbg_rd_req = 1'b1; tick(); dbg_rd_req = 1'b0;
    chk(exc_flag && !dbg_rd_valid, "R9 refused", {30'd0, exc_flag, dbg_rd_valid}, 2);
    sts_wr_en = 1'b1; sts_wr_data = 1'b1; tick(); sts_wr_en = 1'b0;
    chk(!exc_flag, "R11 clear", 32'(exc_flag), 0);
    wr_cfg(mk(1, 0, 1, 0, 15));
    dbg_rd_req = 1'b1; tick(); dbg_rd_req = 1'b0;
    chk(exc_flag && !dbg_rd_valid, "R10 too early", {30'd0, exc_flag, dbg_rd_valid}, 2);
    sts_wr_en = 1'b1; tick(); sts_wr_en = 1'b0;
    pulse_exec();
    dbg_rd_req = 1'b1; tick(); dbg_rd_req = 1'b0;
    chk(dbg_rd_valid && !exc_flag, "R10 armed", {30'd0, dbg_rd_valid, exc_flag}, 2);
    chk(dbg_rd_data == 16'hFFFF, "R9 data", 32'(dbg_rd_data), 32'hFFFF);
    wr_cfg(mk(1, 0, 0, 0, 15));
    dbg_rd_req = 1'b1; sts_wr_en = 1'b1; sts_wr_data = 1'b1;
    tick();
    dbg_rd_req = 1'b0; sts_wr_en = 1'b0;
    chk(exc_flag, "R11 set wins", 32'(exc_flag), 1);
    sts_wr_en = 1'b1; tick(); sts_wr_en = 1'b0;
    chk(!exc_flag, "R11 clear again", 32'(exc_flag), 0);
  endtask

  initial begin
    rst = 1'b1; exec_set = 0; cfg_wr_en = 0; cfg_wr_data = '0;
    cmd_full_flush = 0; cmd_range_flush = 0; fill_en = 0; fill_idx = '0;
    dbg_rd_req = 0; sts_wr_en = 0; sts_wr_data = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_readback();
    t_enable();
    t_full();
    t_range();
    t_stall_ignore();
    t_same_cycle();
    t_disable();
    t_both();
    t_debug();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule